// File: doc/BRIEF.md
# Phase-Aligned Clock Divider Bank

This block is a bank of integer clock dividers that all run from one common source clock. Each channel has its own divide ratio and its own starting phase offset. One shared sync controller merges three requests into a single sync strobe: the falling edge of a software control bit, a rising edge on an external sync pin, and a one-time automatic request on the first PLL lock after reset. On that strobe every channel reloads its settings and restarts. Channels with equal ratios then keep a fixed phase relation that is set only by their offsets.

The logic runs on a clock at twice the source-clock rate, so one tick is one half source period. A phase offset is a count of ticks, from 0 to 63. It delays only the first output period after a sync. After that each channel runs at its plain ratio. The software bit, the lock flag and the settings are synchronous to the bank clock. The pin is asynchronous.

Top module: `phase_div_bank`

## Requirements
- R1: From reset until the first sync strobe, every `clk_out` bit is low.
- R2: With an effective ratio N, an output repeats every 2N ticks. For even N it is high for N ticks. For odd N of 3 or more it is high for N-1 ticks, which is floor(N/2) source periods. A ratio field of 0 acts as N=1.
- R3: The phase field is 6 bits and gives a delay of 0 to 63 ticks. If a channel reloads at edge L, its output is low after L and first rises at edge L+1+P. The high time of the first period then starts from that rise.
- R4: With N=1 the output toggles every tick and first rises at L+1. The phase field has no effect.
- R5: Ratio and phase inputs are captured only at the reload edge. Changing them at any other time leaves the outputs unchanged.
- R6: If `sync_bit` is sampled high at edge e-1 and low at edge e, all channels reload at edge e+1. A rising edge of the bit, or holding it high, causes no reload.
- R7: `sync_pin` is ORed with the bit. It passes through a two-flop synchronizer and a rising-edge detector. If it is first sampled high at edge e, all channels reload at edge e+3. Holding the pin high causes no further reloads.
- R8: If `pll_lock` is first sampled high at edge e after reset, all channels reload at edge e+1. Later drops or rises of the lock flag cause no reload until the next reset.
- R9: All channels reload on the same edge. Two channels with the same ratio and phases P0 and P1 rise P1-P0 ticks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock, twice the source-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pin | input | 1 | External sync request, asynchronous, rising-edge active |
| sync_bit | input | 1 | Software sync control bit, falling-edge active |
| pll_lock | input | 1 | PLL lock flag |
| div_ratio | input | NUM_CH*DIV_W | Per-channel divide ratio, channel c in bits [c*DIV_W +: DIV_W] |
| phase_ofs | input | NUM_CH*PH_W | Per-channel phase offset in ticks, channel c in bits [c*PH_W +: PH_W] |
| clk_out | output | NUM_CH | Per-channel divided clock |

## Verification
Each channel's state is a countdown and a position within the period, so a wrong value shows up on that channel's output within one period of 2N ticks. It appears as a shifted rising edge, a wrong high time or a lost phase relation to a neighbouring channel. A wrong sync controller state shows up as a reload when none should happen, or a missing reload. Either one moves every channel's pattern relative to the model's reload edge, and this is visible from the tick after the expected reload onward. A wrongly captured setting stays hidden until the next reload applies it, so the bench changes the inputs and watches for several periods before and after each sync.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

  localparam int unsigned DIV_W_DEF  = 8;
  localparam int unsigned PH_W_DEF   = 6;
  localparam int unsigned NUM_CH_DEF = 4;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_DELAY = 2'd1,
    CH_RUN   = 2'd2
  } ch_state_e;

endpackage

// File: rtl/pdb_rst_sync.sv
module pdb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pdb_sync_ctrl.sv
module pdb_sync_ctrl #(
  parameter int unsigned SYNC_STAGES = pdb_pkg::SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_pin,
  input  logic sync_bit,
  input  logic pll_lock,
  output logic strobe
);

  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] pin_sh_q, pin_sh_d;
  logic            bit_prev_q, bit_prev_d;
  logic            auto_done_q, auto_done_d;
  logic            strobe_q, strobe_d;
  logic            pin_rise, bit_fall, auto_req;

  // pin: synchronizer stages followed by one history flop for edge detection
  assign pin_rise = pin_sh_q[SYNC_STAGES-1] & ~pin_sh_q[SYNC_STAGES];
  assign bit_fall = bit_prev_q & ~sync_bit;
  assign auto_req = pll_lock & ~auto_done_q;

  always_comb begin
    pin_sh_d    = {pin_sh_q[SH_W-2:0], sync_pin};
    bit_prev_d  = sync_bit;
    auto_done_d = auto_done_q | pll_lock;
    strobe_d    = pin_rise | bit_fall | auto_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sh_q    <= '0;
      bit_prev_q  <= 1'b0;
      auto_done_q <= 1'b0;
      strobe_q    <= 1'b0;
    end else begin
      pin_sh_q    <= pin_sh_d;
      bit_prev_q  <= bit_prev_d;
      auto_done_q <= auto_done_d;
      strobe_q    <= strobe_d;
    end
  end

  assign strobe = strobe_q;

  // R8: the one-shot auto request never re-arms without reset
  p_auto_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    auto_done_q |=> auto_done_q);

  // R8: first lock seen produces a strobe on the following tick
  p_first_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_lock && !auto_done_q) |=> (strobe_q && auto_done_q));

  // R6: a rising control bit with no other request yields no strobe
  p_bit_rise_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_bit && !bit_prev_q && !pin_rise && (auto_done_q || !pll_lock)) |=> !strobe_q);

  // R7: a steady synchronized pin level produces no strobe from the pin path
  p_pin_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sh_q[SYNC_STAGES-1] == pin_sh_q[SYNC_STAGES] && !bit_fall && !auto_req) |=> !strobe_q);

endmodule

// File: rtl/pdb_divider.sv
module pdb_divider
  import pdb_pkg::*;
#(
  parameter int unsigned DIV_W = pdb_pkg::DIV_W_DEF,
  parameter int unsigned PH_W  = pdb_pkg::PH_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [DIV_W-1:0] ratio_in,
  input  logic [PH_W-1:0]  phase_in,
  output logic             clk_out
);

  localparam int unsigned CNT_W = DIV_W + 1;

  ch_state_e        state_q, state_d;
  logic [PH_W-1:0]  dly_q, dly_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic [CNT_W-1:0] high_q, high_d;
  logic             out_q, out_d;
  logic             upd_en;

  logic [DIV_W-1:0] n_eff;
  logic             n_is_one;
  logic [PH_W-1:0]  ph_eff;
  logic [CNT_W-1:0] last_in, high_in;

  // settings decode, used only at the reload edge
  always_comb begin
    n_eff    = (ratio_in == '0) ? DIV_W'(1) : ratio_in;
    n_is_one = (n_eff == DIV_W'(1));
    ph_eff   = n_is_one ? '0 : phase_in;
    last_in  = {n_eff, 1'b0} - CNT_W'(1);
    high_in  = n_is_one ? CNT_W'(1) : {1'b0, n_eff[DIV_W-1:1], 1'b0};
  end

  assign upd_en = strobe | (state_q != CH_IDLE);

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    pos_d   = pos_q;
    last_d  = last_q;
    high_d  = high_q;
    out_d   = out_q;
    if (strobe) begin
      state_d = (ph_eff != '0) ? CH_DELAY : CH_RUN;
      dly_d   = ph_eff;
      pos_d   = '0;
      last_d  = last_in;
      high_d  = high_in;
      out_d   = 1'b0;
    end else begin
      unique case (state_q)
        CH_DELAY: begin
          out_d = 1'b0;
          dly_d = dly_q - PH_W'(1);
          if (dly_q == PH_W'(1)) begin
            state_d = CH_RUN;
          end
        end
        CH_RUN: begin
          out_d = (pos_q < high_q);
          pos_d = (pos_q == last_q) ? '0 : pos_q + CNT_W'(1);
        end
        default: begin
          out_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      dly_q   <= '0;
      pos_q   <= '0;
      last_q  <= '0;
      high_q  <= '0;
      out_q   <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      dly_q   <= dly_d;
      pos_q   <= pos_d;
      last_q  <= last_d;
      high_q  <= high_d;
      out_q   <= out_d;
    end
  end

  assign clk_out = out_q;

  // R3: output is low on the tick after a reload
  p_load_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !clk_out);

  // R1: no output activity before the first reload
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_IDLE) |-> !out_q);

  // R3: output stays low while the phase countdown runs
  p_delay_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_DELAY) |-> (!out_q && dly_q != '0));

  // R2: period position never passes the period end
  p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_RUN) |-> (pos_q <= last_q && high_q <= last_q));

endmodule

// File: rtl/phase_div_bank.sv
module phase_div_bank #(
  parameter int unsigned NUM_CH      = pdb_pkg::NUM_CH_DEF,
  parameter int unsigned DIV_W       = pdb_pkg::DIV_W_DEF,
  parameter int unsigned PH_W        = pdb_pkg::PH_W_DEF,
  parameter int unsigned SYNC_STAGES = pdb_pkg::SYNC_STAGES_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_pin,
  input  logic                     sync_bit,
  input  logic                     pll_lock,
  input  logic [NUM_CH*DIV_W-1:0]  div_ratio,
  input  logic [NUM_CH*PH_W-1:0]   phase_ofs,
  output logic [NUM_CH-1:0]        clk_out
);

  logic rst_n_int;
  logic strobe;

  pdb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pdb_sync_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .sync_pin (sync_pin),
    .sync_bit (sync_bit),
    .pll_lock (pll_lock),
    .strobe   (strobe)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pdb_divider #(.DIV_W(DIV_W), .PH_W(PH_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .strobe   (strobe),
      .ratio_in (div_ratio[c*DIV_W +: DIV_W]),
      .phase_in (phase_ofs[c*PH_W +: PH_W]),
      .clk_out  (clk_out[c])
    );
  end

  // R9: every channel is low on the tick after a shared strobe
  p_common_restart_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    strobe |=> (clk_out == '0));

endmodule

// File: tb/sim_phase_div_bank.sv
`timescale 1ns/1ps
module sim_phase_div_bank;

  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int PW  = 6;
  localparam int NV  = 6;
  localparam int WIN = 150;

  // stimulus vectors: ratios, phases, sync source (0 = control bit, 1 = pin)
  localparam int TV_DIV [NV][NCH] = '{
    '{2, 2, 3, 1}, '{4, 5, 7, 0}, '{1, 6, 9, 2},
    '{3, 3, 3, 3}, '{8, 2, 10, 5}, '{2, 2, 2, 2}};
  localparam int TV_PH [NV][NCH] = '{
    '{0, 6, 0, 5}, '{3, 0, 63, 9}, '{0, 1, 2, 3},
    '{0, 1, 2, 4}, '{7, 63, 0, 11}, '{0, 6, 12, 0}};
  localparam int TV_SRC [NV] = '{0, 1, 0, 1, 0, 0};

  logic clk = 1'b0;
  logic rst_n, sync_pin, sync_bit, pll_lock;
  logic [NCH*DW-1:0] div_ratio;
  logic [NCH*PW-1:0] phase_ofs;
  logic [NCH-1:0]    clk_out;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  int k0 = -1;
  int drv_div [NCH];
  int drv_ph  [NCH];
  int mdl_div [NCH];
  int mdl_ph  [NCH];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      div_ratio[c*DW +: DW] = DW'(drv_div[c]);
      phase_ofs[c*PW +: PW] = PW'(drv_ph[c]);
    end
  end

  phase_div_bank u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_pin  (sync_pin),
    .sync_bit  (sync_bit),
    .pll_lock  (pll_lock),
    .div_ratio (div_ratio),
    .phase_ofs (phase_ofs),
    .clk_out   (clk_out)
  );

  function automatic logic exp_out(int n, int p, int k);
    int ne, pe, t, h, m;
    ne = (n == 0) ? 1 : n;
    pe = (ne == 1) ? 0 : p;
    t  = 2 * ne;
    h  = (ne == 1) ? 1 : 2 * (ne / 2);
    if (k <= 0) return 1'b0;
    m = k - 1 - pe;
    if (m < 0) return 1'b0;
    return ((m % t) < h);
  endfunction

  // compare every channel for len ticks against the model; one check per channel
  task automatic watch(int len, string req);
    int   bad [NCH];
    int   fk  [NCH];
    logic fa  [NCH];
    logic fe  [NCH];
    logic e;
    for (int c = 0; c < NCH; c++) bad[c] = 0;
    repeat (len) begin
      @(negedge clk);
      if (k0 < 0 || cyc >= k0) begin
        for (int c = 0; c < NCH; c++) begin
          e = (k0 < 0) ? 1'b0 : exp_out(mdl_div[c], mdl_ph[c], cyc - k0);
          if (clk_out[c] !== e) begin
            if (bad[c] == 0) begin
              fk[c] = cyc; fa[c] = clk_out[c]; fe[c] = e;
            end
            bad[c]++;
          end
        end
      end
    end
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (bad[c] != 0) begin
        failures++;
        $display("FAIL %s ch%0d edge %0d: actual=%b expected=%b", req, c, fk[c], fa[c], fe[c]);
      end
    end
  endtask

  task automatic set_drv(int v);
    for (int c = 0; c < NCH; c++) begin
      drv_div[c] = TV_DIV[v][c];
      drv_ph[c]  = TV_PH[v][c];
    end
  endtask

  task automatic adopt();
    for (int c = 0; c < NCH; c++) begin
      mdl_div[c] = drv_div[c];
      mdl_ph[c]  = drv_ph[c];
    end
  endtask

  task automatic bit_sync();
    @(negedge clk); sync_bit = 1'b1;
    @(negedge clk); sync_bit = 1'b0;
    k0 = cyc + 2;
    adopt();
  endtask

  task automatic pin_rise();
    @(negedge clk); sync_pin = 1'b1;
    k0 = cyc + 4;
    adopt();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sync_pin = 1'b0; sync_bit = 1'b0; pll_lock = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    k0 = -1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync_pin = 1'b0; sync_bit = 1'b0; pll_lock = 1'b0;
    set_drv(0);
    do_reset();

    // R1: outputs low and quiet before any sync
    watch(30, "R1");

    // R8: first lock triggers the automatic sync
    @(negedge clk); pll_lock = 1'b1;
    k0 = cyc + 2; adopt();
    watch(WIN, "R8/R9/R4");

    // vector table: R2 R3 R4 R6 R7 R9 under several ratio/phase mixes
    for (int v = 0; v < NV; v++) begin
      set_drv(v);
      if (TV_SRC[v] == 0) begin
        bit_sync();
        watch(WIN, "R2/R3/R4/R6/R9");
      end else begin
        pin_rise();
        watch(WIN, "R2/R3/R4/R7/R9");
        @(negedge clk); sync_pin = 1'b0;
      end
    end

    // R5: new settings without a sync change nothing
    set_drv(1);
    watch(80, "R5");

    // R6: raising and holding the control bit does not resync
    @(negedge clk); sync_bit = 1'b1;
    watch(80, "R6");
    @(negedge clk); sync_bit = 1'b0;
    k0 = cyc + 2; adopt();
    watch(WIN, "R6/R5");

    // R7: pin held high resyncs once only
    set_drv(4);
    pin_rise();
    watch(WIN, "R7");
    set_drv(2);
    watch(80, "R7");
    @(negedge clk); sync_pin = 1'b0;
    watch(40, "R7");

    // R8: lock drop and return after the first lock causes no reload
    @(negedge clk); pll_lock = 1'b0;
    watch(40, "R8");
    set_drv(3);
    @(negedge clk); pll_lock = 1'b1;
    watch(80, "R8");

    // R8/R1: reset re-arms the automatic sync
    do_reset();
    watch(20, "R1");
    @(negedge clk); pll_lock = 1'b1;
    k0 = cyc + 2; adopt();
    watch(WIN, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule